// File: doc/BRIEF.md
# Indexed-Buffer SPI Command Engine

This block runs single SPI commands out of a small, directly addressable byte buffer. Software reaches it through an 8-bit register window. It enables the engine and writes an opcode, a transmit count and a receive count. It places the outgoing bytes at the bottom of a 71-byte buffer and then sets a start bit. The engine pulls chip select low and shifts out the opcode followed by the transmit bytes. It then clocks in the requested number of response bytes and stores each one in the buffer directly after the transmit data, wrapping at the buffer end.

Clocking uses SPI mode 0. SCLK idles low, data is sent most-significant bit first, the engine samples MISO on the rising edge and changes MOSI on the falling edge. A 16-bit speed register holds four 4-bit speed selects for different access types. Only the normal-speed field drives this engine's SCLK, and it is captured when a command starts. The start bit reads back as 1 for as long as the command runs, so software can poll it.

Top module: `spi_cmd_engine`

## Requirements
- R1: Offset 0x20 bit 0 (engine enable), offset 0x45 (opcode), 0x48 (transmit count), 0x4B (receive count) and the speed register read back as written. The speed register is 0x22 for bits 7:0 and 0x23 for bits 15:8, with normal speed in 15:12, fast in 11:8, alternate in 7:4 and the fourth select in 3:0. Unused enable bits read 0.
- R2: Writing bit 7 = 1 to offset 0x47 while the engine is enabled and idle starts a command. Bit 7 of 0x47 reads 1 from the next cycle until the command ends, then reads 0.
- R3: A start write while the enable bit is 0 is ignored: bit 7 of 0x47 stays 0 and chip select stays high.
- R4: During a command, chip select stays low without a break for the opcode, every transmit byte and every receive byte. SCLK is low whenever chip select is high. Bits go out MSB first in mode 0: the opcode, then buffer indices 0 to tx-1, then 0x00 for each receive byte.
- R5: Receive byte i is written to buffer index (tx + i) mod 71. No other buffer byte changes.
- R6: A transmit or receive count above 68 is used as 68. The register itself still reads back the value written.
- R7: While a command runs, writes to the opcode, the two count registers and the buffer have no effect.
- R8: The SCLK half period in core clocks follows the normal-speed code: 4 gives 1, 0 gives 2, 1 gives 3, 2 gives 4 and 3 gives 5. Codes 7, the reserved codes 5 and 6, and every other value give SLOW_HALF, which is 8 by default.
- R9: Buffer byte k is read and written at offset 0x80+k for k from 0 to 70. Offsets that map to no register read 0, including 0xC7.
- R10: After reset, chip select is high, SCLK is low, the engine is idle, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Register window byte offset |
| host_we | input | 1 | Write strobe for host_wdata at host_addr |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A wrong buffer pointer or a missed wrap shows up when the buffer is read back after the start bit clears. A response byte lands at the wrong index, or a transmit byte changes when it should not. A 68-plus-68 command shows this within one transaction. A miscounted bit or byte counter changes the captured MOSI stream or the number of SCLK edges while chip select is low, so the frame check reports it at the end of that same command. A wrong divider selection changes the measured SCLK high time on the first bit after start. A leaked busy-time write or a start that is not blocked changes a register readback or the start bit a few cycles later.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam logic [7:0] OFS_ENABLE  = 8'h20;
  localparam logic [7:0] OFS_SPEED_L = 8'h22;
  localparam logic [7:0] OFS_SPEED_H = 8'h23;
  localparam logic [7:0] OFS_OPCODE  = 8'h45;
  localparam logic [7:0] OFS_TRIG    = 8'h47;
  localparam logic [7:0] OFS_TXCNT   = 8'h48;
  localparam logic [7:0] OFS_RXCNT   = 8'h4B;
  localparam logic [7:0] OFS_BUF     = 8'h80;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SHIFT, SQ_TAIL} seq_state_e;
  typedef enum logic [1:0] {PH_OP, PH_TX, PH_RX} byte_phase_e;

  // SCLK half period, in core clocks, for a normal-speed code
  function automatic int unsigned half_of(logic [3:0] code, int unsigned slow);
    case (code)
      4'd4:    return 1;
      4'd0:    return 2;
      4'd1:    return 3;
      4'd2:    return 4;
      4'd3:    return 5;
      default: return slow;
    endcase
  endfunction

endpackage

// File: rtl/spi_eng_buf.sv
module spi_eng_buf #(
  parameter int DEPTH = 71,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_widx,
  input  logic [7:0]       eng_wdata,
  input  logic [IDX_W-1:0] eng_ridx,
  output logic [7:0]       eng_rdata
);

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [7:0] q;
    logic       hit_e, hit_h;
    assign hit_e = eng_we  && (eng_widx == IDX_W'(g));
    assign hit_h = host_we && (host_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (hit_e) q <= eng_wdata;
      else if (hit_h) q <= host_wdata;
    end
    assign mem[g] = q;
  end

  assign host_rdata = (int'(host_idx) < DEPTH) ? mem[host_idx] : 8'h00;
  assign eng_rdata  = (int'(eng_ridx) < DEPTH) ? mem[eng_ridx] : 8'h00;

endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 71,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       host_addr,
  input  logic             host_we,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             busy,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_idx,
  output logic             en_q,
  output logic [15:0]      speed_q,
  output logic [7:0]       opcode_q,
  output logic [7:0]       tx_cnt_q,
  output logic [7:0]       rx_cnt_q,
  output logic             go
);

  logic [7:0] buf_ofs;
  logic       buf_hit, open_wr;
  logic       en_d;
  logic [15:0] speed_d;
  logic [7:0] opcode_d, tx_d, rx_d;

  assign buf_ofs = host_addr - OFS_BUF;
  assign buf_hit = (host_addr >= OFS_BUF) && (int'(buf_ofs) < DEPTH);
  assign buf_idx = buf_ofs[IDX_W-1:0];
  assign open_wr = host_we && !busy;
  assign buf_we  = open_wr && buf_hit;
  assign go      = host_we && (host_addr == OFS_TRIG) && host_wdata[7] && en_q && !busy;

  always_comb begin
    en_d     = en_q;
    speed_d  = speed_q;
    opcode_d = opcode_q;
    tx_d     = tx_cnt_q;
    rx_d     = rx_cnt_q;
    if (host_we) begin
      if (host_addr == OFS_ENABLE)  en_d          = host_wdata[0];
      if (host_addr == OFS_SPEED_L) speed_d[7:0]  = host_wdata;
      if (host_addr == OFS_SPEED_H) speed_d[15:8] = host_wdata;
    end
    if (open_wr) begin
      if (host_addr == OFS_OPCODE) opcode_d = host_wdata;
      if (host_addr == OFS_TXCNT)  tx_d     = host_wdata;
      if (host_addr == OFS_RXCNT)  rx_d     = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      speed_q  <= '0;
      opcode_q <= '0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
    end else begin
      en_q     <= en_d;
      speed_q  <= speed_d;
      opcode_q <= opcode_d;
      tx_cnt_q <= tx_d;
      rx_cnt_q <= rx_d;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (buf_hit) host_rdata = buf_rdata;
    else begin
      case (host_addr)
        OFS_ENABLE:  host_rdata = {7'b0, en_q};
        OFS_SPEED_L: host_rdata = speed_q[7:0];
        OFS_SPEED_H: host_rdata = speed_q[15:8];
        OFS_OPCODE:  host_rdata = opcode_q;
        OFS_TRIG:    host_rdata = {busy, 7'b0};
        OFS_TXCNT:   host_rdata = tx_cnt_q;
        OFS_RXCNT:   host_rdata = rx_cnt_q;
        default:     host_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == half - CNT_W'(1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter int DEPTH     = 71,
  parameter int MAX_XFER  = 68,
  parameter int SLOW_HALF = 8,
  parameter int IDX_W     = $clog2(DEPTH),
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       opcode,
  input  logic [7:0]       tx_cnt,
  input  logic [7:0]       rx_cnt,
  input  logic [3:0]       speed_norm,
  input  logic             tick,
  input  logic             miso,
  input  logic [7:0]       eng_rdata,
  output logic             busy,
  output logic [CNT_W-1:0] half,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             eng_we,
  output logic [IDX_W-1:0] eng_widx,
  output logic [7:0]       eng_wdata,
  output logic [IDX_W-1:0] eng_ridx
);

  seq_state_e  st_q, st_d;
  byte_phase_e ph_q, ph_d;
  logic [7:0]  sh_q, sh_d, rxsh_q, rxsh_d;
  logic [2:0]  bit_q, bit_d;
  logic [IDX_W-1:0] ptr_q, ptr_d, ptr_n;
  logic [7:0]  txl_q, txl_d, rxl_q, rxl_d, tx_rem, rx_rem;
  logic        sclk_q, sclk_d, cs_q, cs_d;
  logic [CNT_W-1:0] half_q, half_d;

  function automatic logic [7:0] clamp(logic [7:0] v);
    return (int'(v) > MAX_XFER) ? 8'(MAX_XFER) : v;
  endfunction

  assign tx_rem = (ph_q == PH_TX) ? txl_q - 8'd1 : txl_q;
  assign rx_rem = (ph_q == PH_RX) ? rxl_q - 8'd1 : rxl_q;
  assign ptr_n  = (ph_q == PH_OP) ? ptr_q :
                  (int'(ptr_q) == DEPTH - 1) ? '0 : ptr_q + IDX_W'(1);

  assign busy      = (st_q != SQ_IDLE);
  assign half      = half_q;
  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign mosi      = !cs_q && sh_q[7];
  assign eng_widx  = ptr_q;
  assign eng_wdata = rxsh_q;
  assign eng_ridx  = ptr_n;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    sh_d   = sh_q;
    rxsh_d = rxsh_q;
    bit_d  = bit_q;
    ptr_d  = ptr_q;
    txl_d  = txl_q;
    rxl_d  = rxl_q;
    sclk_d = sclk_q;
    cs_d   = cs_q;
    half_d = half_q;
    eng_we = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (go) begin
          st_d   = SQ_SHIFT;
          ph_d   = PH_OP;
          cs_d   = 1'b0;
          sclk_d = 1'b0;
          sh_d   = opcode;
          bit_d  = '0;
          ptr_d  = '0;
          txl_d  = clamp(tx_cnt);
          rxl_d  = clamp(rx_cnt);
          half_d = CNT_W'(half_of(speed_norm, SLOW_HALF));
        end
      end
      SQ_SHIFT: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rxsh_d = {rxsh_q[6:0], miso};
          end else begin
            sclk_d = 1'b0;
            if (bit_q != 3'd7) begin
              bit_d = bit_q + 3'd1;
              sh_d  = {sh_q[6:0], 1'b0};
            end else begin
              bit_d  = '0;
              eng_we = (ph_q == PH_RX);
              txl_d  = tx_rem;
              rxl_d  = rx_rem;
              ptr_d  = ptr_n;
              if (tx_rem != 8'd0) begin
                ph_d = PH_TX;
                sh_d = eng_rdata;
              end else if (rx_rem != 8'd0) begin
                ph_d = PH_RX;
                sh_d = 8'h00;
              end else begin
                st_d = SQ_TAIL;
              end
            end
          end
        end
      end
      SQ_TAIL: begin
        if (tick) begin
          cs_d = 1'b1;
          st_d = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      ph_q   <= PH_OP;
      sh_q   <= '0;
      rxsh_q <= '0;
      bit_q  <= '0;
      ptr_q  <= '0;
      txl_q  <= '0;
      rxl_q  <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      half_q <= CNT_W'(1);
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      sh_q   <= sh_d;
      rxsh_q <= rxsh_d;
      bit_q  <= bit_d;
      ptr_q  <= ptr_d;
      txl_q  <= txl_d;
      rxl_q  <= rxl_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      half_q <= half_d;
    end
  end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int DEPTH     = 71,
  parameter int MAX_XFER  = 68,
  parameter int SLOW_HALF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_addr,
  input  logic       host_we,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int IDX_W    = $clog2(DEPTH);
  localparam int HALF_MAX = (SLOW_HALF > 5) ? SLOW_HALF : 5;
  localparam int CNT_W    = $clog2(HALF_MAX + 1);

  logic rst_s1, rst_sync_n;
  logic busy, go, tick, en_q;
  logic [15:0] speed_q;
  logic [7:0]  opcode_q, tx_cnt_q, rx_cnt_q;
  logic        hbuf_we, eng_we;
  logic [IDX_W-1:0] hbuf_idx, eng_widx, eng_ridx;
  logic [7:0]  hbuf_rdata, eng_wdata, eng_rdata;
  logic [CNT_W-1:0] half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  spi_eng_regs #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy), .buf_rdata(hbuf_rdata),
    .buf_we(hbuf_we), .buf_idx(hbuf_idx), .en_q(en_q), .speed_q(speed_q),
    .opcode_q(opcode_q), .tx_cnt_q(tx_cnt_q), .rx_cnt_q(rx_cnt_q), .go(go)
  );

  spi_eng_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_sync_n),
    .host_we(hbuf_we), .host_idx(hbuf_idx), .host_wdata(host_wdata),
    .host_rdata(hbuf_rdata), .eng_we(eng_we), .eng_widx(eng_widx),
    .eng_wdata(eng_wdata), .eng_ridx(eng_ridx), .eng_rdata(eng_rdata)
  );

  spi_eng_clkdiv #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .run(busy), .half(half), .tick(tick)
  );

  spi_eng_seq #(
    .DEPTH(DEPTH), .MAX_XFER(MAX_XFER), .SLOW_HALF(SLOW_HALF),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .go(go), .opcode(opcode_q),
    .tx_cnt(tx_cnt_q), .rx_cnt(rx_cnt_q), .speed_norm(speed_q[15:12]),
    .tick(tick), .miso(spi_miso), .eng_rdata(eng_rdata), .busy(busy),
    .half(half), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata),
    .eng_ridx(eng_ridx)
  );

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] host_addr,
  input logic       host_we,
  input logic       trig_bit,
  input logic       busy,
  input logic       en,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic [7:0] tx_cnt_q,
  input logic [7:0] opcode_q
);

  // R4
  cs_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk) |=> (!sclk || $stable(mosi)));

  // R3
  trig_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en && host_we && host_addr == 8'h47) |=> !busy);

  // R2
  trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && en && host_we && host_addr == 8'h47 && trig_bit) |=> busy);

  // R7
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we) |=> ($stable(tx_cnt_q) && $stable(opcode_q)));

endmodule

bind spi_cmd_engine spi_eng_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_addr(host_addr), .host_we(host_we),
  .trig_bit(host_wdata[7]), .busy(busy), .en(en_q), .cs_n(spi_cs_n),
  .sclk(spi_sclk), .mosi(spi_mosi), .tx_cnt_q(tx_cnt_q), .opcode_q(opcode_q)
);

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;

  localparam int DEPTH = 71;
  localparam int MAXX  = 68;
  localparam int SLOW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] host_addr = 8'h00;
  logic host_we = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  spi_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #4 clk = ~clk;

  // ---------- device model ----------
  logic [7:0] model_buf [DEPTH];
  logic [7:0] rx_pat [MAXX];
  logic       cap [2000];
  int sbit = 0;
  int ncap = 0;
  int cur_tx = 0;

  always @(negedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) sbit <= 0;
    else          sbit <= sbit + 1;
  end

  always @(posedge spi_sclk) begin
    if (sbit < 2000) cap[sbit] <= spi_mosi;
    ncap <= sbit + 1;
  end

  always_comb begin
    int b;
    b = sbit / 8 - 1 - cur_tx;
    if (!spi_cs_n && b >= 0 && b < MAXX) spi_miso = rx_pat[b][7 - (sbit % 8)];
    else spi_miso = 1'b0;
  end

  // ---------- helpers ----------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    v = 8'h80;
    while (v[7]) rd(8'h47, v);
  endtask

  function automatic int clampc(int v);
    return (v > MAXX) ? MAXX : v;
  endfunction

  function automatic int exp_half(int code);
    case (code)
      4: return 1;
      0: return 2;
      1: return 3;
      2: return 4;
      3: return 5;
      default: return SLOW;
    endcase
  endfunction

  task automatic fill_buf();
    for (int k = 0; k < DEPTH; k++) begin
      model_buf[k] = 8'($urandom);
      wr(8'h80 + 8'(k), model_buf[k]);
    end
  endtask

  task automatic check_buf(input string req);
    logic [7:0] v;
    int bad;
    bad = 0;
    for (int k = 0; k < DEPTH; k++) begin
      rd(8'h80 + 8'(k), v);
      if (v !== model_buf[k] && bad == 0) begin
        bad = 1;
        chk(1'b0, req, int'(v), int'(model_buf[k]));
      end
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
  endtask

  // full command: load, run, check frame and buffer
  task automatic run_cmd(input logic [7:0] op, input int txw, input int rxw);
    logic [7:0] v;
    logic [7:0] exp_bytes [1 + 2*MAXX];
    int etx, erx, nb, bad;
    etx = clampc(txw);
    erx = clampc(rxw);
    for (int i = 0; i < MAXX; i++) rx_pat[i] = 8'($urandom);
    wr(8'h45, op);
    wr(8'h48, 8'(txw));
    wr(8'h4B, 8'(rxw));
    cur_tx = etx;
    exp_bytes[0] = op;
    for (int i = 0; i < etx; i++) exp_bytes[1 + i] = model_buf[i];
    for (int i = 0; i < erx; i++) exp_bytes[1 + etx + i] = 8'h00;
    nb = 1 + etx + erx;
    wr(8'h47, 8'h80);
    rd(8'h47, v);
    chk(v[7] == 1'b1, "R2 busy after start", int'(v), 8'h80);
    chk(spi_cs_n == 1'b0, "R4 cs low during command", int'(spi_cs_n), 0);
    wait_idle();
    rd(8'h47, v);
    chk(v[7] == 1'b0, "R2 start bit cleared", int'(v), 0);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R4 idle pins",
        int'({spi_cs_n, spi_sclk}), 2);
    chk(ncap == nb * 8, "R6 bit count of frame", ncap, nb * 8);
    bad = 0;
    for (int bi = 0; bi < nb * 8 && bi < 2000; bi++) begin
      if (cap[bi] !== exp_bytes[bi / 8][7 - (bi % 8)] && bad == 0) begin
        bad = 1;
        chk(1'b0, "R4 mosi stream", bi, int'(exp_bytes[bi / 8]));
      end
    end
    if (bad == 0) chk(1'b1, "R4 mosi stream", 0, 0);
    for (int i = 0; i < erx; i++) model_buf[(etx + i) % DEPTH] = rx_pat[i];
    check_buf("R5 receive placement");
  endtask

  task automatic measure_speed(input int code);
    logic [7:0] v;
    int hi;
    wr(8'h23, 8'(code << 4));
    wr(8'h48, 8'd0);
    wr(8'h4B, 8'd0);
    wr(8'h47, 8'h80);
    hi = 0;
    while (!spi_sclk) @(negedge clk);
    while (spi_sclk) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == exp_half(code), "R8 sclk half period", hi, exp_half(code));
    wait_idle();
    rd(8'h23, v);
  endtask

  // ---------- watchdog ----------
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------- main ----------
  initial begin
    logic [7:0] v;
    logic [7:0] ofs [8];
    void'($urandom(32'd5150));
    ofs = '{8'h20, 8'h22, 8'h23, 8'h45, 8'h47, 8'h48, 8'h4B, 8'h80};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R10 pins after reset",
        int'({spi_cs_n, spi_sclk}), 2);
    for (int i = 0; i < 8; i++) begin
      rd(ofs[i], v);
      chk(v == 8'h00, "R10 register zero after reset", int'(v), 0);
    end

    // R1 readback
    wr(8'h20, 8'hFF);
    rd(8'h20, v); chk(v == 8'h01, "R1 enable readback", int'(v), 1);
    wr(8'h22, 8'h7A);
    wr(8'h23, 8'h4C);
    rd(8'h22, v); chk(v == 8'h7A, "R1 speed low byte", int'(v), 8'h7A);
    rd(8'h23, v); chk(v == 8'h4C, "R1 speed high byte", int'(v), 8'h4C);
    wr(8'h45, 8'h9F); rd(8'h45, v); chk(v == 8'h9F, "R1 opcode", int'(v), 8'h9F);
    wr(8'h48, 8'd100); rd(8'h48, v); chk(v == 8'd100, "R6 tx count stored raw", int'(v), 100);
    wr(8'h4B, 8'd3); rd(8'h4B, v); chk(v == 8'd3, "R1 rx count", int'(v), 3);

    // R9 buffer and unmapped
    fill_buf();
    check_buf("R9 buffer readback");
    rd(8'hC7, v); chk(v == 8'h00, "R9 unmapped 0xC7", int'(v), 0);
    rd(8'h21, v); chk(v == 8'h00, "R9 unmapped 0x21", int'(v), 0);

    // R3 disabled start
    wr(8'h20, 8'h00);
    wr(8'h47, 8'h80);
    repeat (4) @(negedge clk);
    rd(8'h47, v); chk(v == 8'h00, "R3 start ignored when disabled", int'(v), 0);
    chk(spi_cs_n == 1'b1, "R3 cs stays high", int'(spi_cs_n), 1);
    wr(8'h20, 8'h01);

    // directed commands at fastest clock
    wr(8'h23, 8'h40);
    run_cmd(8'h06, 0, 0);
    run_cmd(8'h9F, 0, 5);
    run_cmd(8'h03, 4, 4);
    run_cmd(8'h02, 68, 68);
    run_cmd(8'h0B, 100, 200);

    // random commands
    for (int n = 0; n < 6; n++) begin
      fill_buf();
      run_cmd(8'($urandom), int'($urandom % 21), int'($urandom % 21));
    end

    // R7 writes during busy ignored (slow clock)
    wr(8'h23, 8'h70);
    wr(8'h45, 8'hAB);
    wr(8'h48, 8'd10);
    wr(8'h4B, 8'd10);
    for (int i = 0; i < MAXX; i++) rx_pat[i] = 8'($urandom);
    cur_tx = 10;
    wr(8'h47, 8'h80);
    wr(8'h48, 8'h33);
    wr(8'h4B, 8'h22);
    wr(8'h45, 8'h11);
    wr(8'h80, ~model_buf[0]);
    wr(8'h90, ~model_buf[16]);
    wait_idle();
    rd(8'h48, v); chk(v == 8'd10, "R7 tx count locked", int'(v), 10);
    rd(8'h4B, v); chk(v == 8'd10, "R7 rx count locked", int'(v), 10);
    rd(8'h45, v); chk(v == 8'hAB, "R7 opcode locked", int'(v), 8'hAB);
    for (int i = 0; i < 10; i++) model_buf[10 + i] = rx_pat[i];
    check_buf("R7 buffer locked");

    // R8 divider per code, including reserved
    for (int c = 0; c < 8; c++) measure_speed(c);
    measure_speed(15);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule